// File: doc/BRIEF.md
# Down-Counting Compare Timer

A 32-bit timer that counts downward from a software-chosen start value. A 12-bit prescaler divides the input clock, so the counter takes one step every (divider+1) clocks. When a counting step lands the counter on the value held in a separate compare register, the block does three things:

- it latches a match flag;
- it raises a level interrupt if that interrupt is enabled;
- it acts on an output pin in one of four ways.

At zero the counter either reloads from a load register (periodic mode) or wraps to all ones (free-running mode). Setting the load register to all ones and enabling the timer gives a plain 32-bit time base. Software reads that time base by negating the live count. It schedules the next event by writing the current count minus the delta into the compare register.

Software sees five word registers through a single write strobe and a combinational read port:

| Offset | Register | Access |
|--------|----------|--------|
| 0x00 | control | read/write |
| 0x04 | status | bit 0 is the match flag, cleared by writing one |
| 0x08 | load | read/write |
| 0x0C | compare | read/write |
| 0x10 | live count | read only |

Unused offsets read zero. The count is sequenced by a two-state machine:

- **ST_OFF**: the counter holds its value.
- **ST_RUN**: the counter steps on every prescaler tick.

It has three named transitions:

- **START** (ST_OFF to ST_RUN): a control write that sets the enable bit while the timer is off.
- **STOP** (ST_RUN to ST_OFF): the enable bit is found clear with no START in the same cycle.
- **SOFT_RESET** (any state to ST_OFF): a control write with the soft-reset bit set.

Top module: `cmp_down_timer`

## Requirements
- R1: After reset, the registers read as follows: control 0, status 0, load 0xFFFFFFFF, compare 0, count 0. `irq` and `out_pin` are low.
- R2: Control fields sit at these bits:
  - bit 0: enable
  - bit 1: load-on-start
  - bit 2: interrupt enable
  - bit 3: reload mode
  - bits 15:4: divider
  - bit 16: soft reset
  - bit 17: immediate overwrite
  - bits 23:22: pin mode

  Control reads back these fields, with bit 16 and all unlisted bits reading 0.
- R3: While enabled, the counter steps once every (divider+1) clocks. The first step comes divider+1 clocks after START.
- R4: On START with load-on-start set, the counter is loaded in the same clock: with the load value if reload mode is set, otherwise with 0xFFFFFFFF. With load-on-start clear, the counter resumes from its held value.
- R5: While enable is clear, the count does not change except through a write.
- R6: In reload mode, a step taken at zero loads the load value, so the period is load+1 steps.
- R7: In free-running mode, a step taken at zero gives 0xFFFFFFFF.
- R8: Status bit 0 is set in the clock where a counting step makes the count equal the compare value.
- R9: Writing 1 to status bit 0 clears the flag, and writing 0 leaves it unchanged. A match in the same clock as the clear wins.
- R10: `irq` is high exactly while the flag and the interrupt enable are both set.
- R11: On each match, pin mode 1 toggles the pin, 2 drives it low and 3 drives it high. Mode 0 drives `out_pin` low and leaves the pin state untouched.
- R12: With immediate overwrite set, a load write also copies the data into the counter in the same clock. With it clear, the counter is unaffected.
- R13: A control write with bit 16 set clears, in that clock:
  - the control register
  - the counter
  - the flag
  - the pin

  Load and compare are kept, and the soft-reset bit never reads back as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one word per clock |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 1 | Level interrupt |
| out_pin | output | 1 | Compare-driven output pin |

## Verification
Counting is tried under four patterns, each of which separates one pair of behaviours:

- **Divider of three**: separates a prescaler that steps every divider+1 clocks from one that is off by a clock.
- **Divider of zero with reload and a small load value**: tells reload at zero apart from wrap, and shows that the match repeats with period load+1.
- **Free run from a held zero**: tells a resume-from-hold start apart from a load-on-start, and wrap apart from reload.
- **Counter overwritten through the load register, followed by a fresh compare value**: separates overwrite from a plain load write.

Each pin mode is checked against the pin's previous level, so toggle, clear and set cannot pass for one another. The flag clear is tried with both a zero and a one written.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    localparam int CNT_W  = 32;
    localparam int PRE_W  = 12;
    localparam int ADDR_W = 5;

    // register offsets
    localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_LOAD = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_CMP  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 5'h10;

    // control bit positions
    localparam int BIT_EN    = 0;
    localparam int BIT_ENMOD = 1;
    localparam int BIT_IRQEN = 2;
    localparam int BIT_RLD   = 3;
    localparam int PRE_LSB   = 4;
    localparam int BIT_SWR   = 16;
    localparam int BIT_OVW   = 17;
    localparam int PIN_LSB   = 22;

    typedef enum logic [1:0] {
        PIN_OFF    = 2'd0,
        PIN_TOGGLE = 2'd1,
        PIN_CLEAR  = 2'd2,
        PIN_SET    = 2'd3
    } pin_mode_e;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } cnt_state_e;

    typedef struct packed {
        logic             run;
        logic             load_on_start;
        logic             irq_en;
        logic             reload;
        logic [PRE_W-1:0] presc;
        logic             overwrite;
        pin_mode_e        pin_mode;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_word(input logic [CNT_W-1:0] w);
        ctrl_t c;
        c.run           = w[BIT_EN];
        c.load_on_start = w[BIT_ENMOD];
        c.irq_en        = w[BIT_IRQEN];
        c.reload        = w[BIT_RLD];
        c.presc         = w[PRE_LSB +: PRE_W];
        c.overwrite     = w[BIT_OVW];
        c.pin_mode      = pin_mode_e'(w[PIN_LSB +: 2]);
        return c;
    endfunction

    function automatic logic [CNT_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [CNT_W-1:0] w;
        w                   = '0;
        w[BIT_EN]           = c.run;
        w[BIT_ENMOD]        = c.load_on_start;
        w[BIT_IRQEN]        = c.irq_en;
        w[BIT_RLD]          = c.reload;
        w[PRE_LSB +: PRE_W] = c.presc;
        w[BIT_OVW]          = c.overwrite;
        w[PIN_LSB +: 2]     = c.pin_mode;
        return w;
    endfunction

endpackage

// File: rtl/cdt_regs.sv
module cdt_regs
    import cdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              flag,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  load_val,
    output logic [CNT_W-1:0]  cmp_val,
    output logic              soft_rst,
    output logic              ack,
    output logic              ovw_pulse,
    output logic              start_pulse,
    output logic              start_load,
    output logic [CNT_W-1:0]  start_val
);

    logic wr_ctrl, wr_stat, wr_load, wr_cmp;

    // write decode
    always_comb begin
        wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
        wr_stat = bus_wr && (bus_addr == OFS_STAT);
        wr_load = bus_wr && (bus_addr == OFS_LOAD);
        wr_cmp  = bus_wr && (bus_addr == OFS_CMP);
    end

    // command pulses derived from the written word
    always_comb begin
        soft_rst    = wr_ctrl && bus_wdata[BIT_SWR];
        ack         = wr_stat && bus_wdata[0];
        ovw_pulse   = wr_load && ctrl.overwrite;
        start_pulse = wr_ctrl && !bus_wdata[BIT_SWR] && bus_wdata[BIT_EN] && !ctrl.run;
        start_load  = start_pulse && bus_wdata[BIT_ENMOD];
        start_val   = bus_wdata[BIT_RLD] ? load_val : '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl     <= '0;
            load_val <= '1;
            cmp_val  <= '0;
        end else begin
            if (soft_rst) begin
                ctrl <= '0;
            end else if (wr_ctrl) begin
                ctrl <= ctrl_from_word(bus_wdata);
            end
            if (wr_load) begin
                load_val <= bus_wdata;
            end
            if (wr_cmp) begin
                cmp_val <= bus_wdata;
            end
        end
    end

    // read port
    always_comb begin
        case (bus_addr)
            OFS_CTRL: bus_rdata = ctrl_to_word(ctrl);
            OFS_STAT: bus_rdata = {{(CNT_W-1){1'b0}}, flag};
            OFS_LOAD: bus_rdata = load_val;
            OFS_CMP:  bus_rdata = cmp_val;
            OFS_CNT:  bus_rdata = cnt_val;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cdt_presc.sv
module cdt_presc #(
    parameter int W = cdt_pkg::PRE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         restart,
    input  logic [W-1:0] divider,
    output logic         tick
);

    logic [W-1:0] phase;

    // a lowered divider still ends the current phase at once
    assign tick = enable && (phase >= divider);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (restart || !enable || tick) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

endmodule

// File: rtl/cdt_count.sv
module cdt_count
    import cdt_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic         run,
    input  logic         tick,
    input  logic         reload,
    input  logic         start_pulse,
    input  logic         start_load,
    input  logic [W-1:0] start_val,
    input  logic         ovw_pulse,
    input  logic [W-1:0] ovw_val,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] cmp_val,
    output logic [W-1:0] cnt,
    output logic         hit
);

    cnt_state_e state, state_nxt;
    logic [W-1:0] cnt_nxt;

    // next-state logic: START, STOP, SOFT_RESET
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OFF: if (start_pulse)                 state_nxt = ST_RUN;
            ST_RUN: if (soft_rst)                    state_nxt = ST_OFF;
                    else if (!run && !start_pulse)   state_nxt = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nxt;
    end

    // counter datapath and match detection
    always_comb begin
        cnt_nxt = cnt;
        hit     = 1'b0;
        if (soft_rst) begin
            cnt_nxt = '0;
        end else if (ovw_pulse) begin
            cnt_nxt = ovw_val;
        end else if (start_load) begin
            cnt_nxt = start_val;
        end else if (state == ST_RUN && tick) begin
            if (cnt == '0) cnt_nxt = reload ? load_val : '1;
            else           cnt_nxt = cnt - 1'b1;
            hit = (cnt_nxt == cmp_val);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_nxt;
    end

endmodule

// File: rtl/cdt_event.sv
module cdt_event
    import cdt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      soft_rst,
    input  logic      hit,
    input  logic      ack,
    input  logic      irq_en,
    input  pin_mode_e pin_mode,
    output logic      flag,
    output logic      irq,
    output logic      out_pin
);

    logic pin_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag  <= 1'b0;
            pin_q <= 1'b0;
        end else if (soft_rst) begin
            flag  <= 1'b0;
            pin_q <= 1'b0;
        end else begin
            if (hit)      flag <= 1'b1;
            else if (ack) flag <= 1'b0;
            if (hit) begin
                unique case (pin_mode)
                    PIN_OFF:    pin_q <= pin_q;
                    PIN_TOGGLE: pin_q <= !pin_q;
                    PIN_CLEAR:  pin_q <= 1'b0;
                    PIN_SET:    pin_q <= 1'b1;
                endcase
            end
        end
    end

    assign irq     = flag && irq_en;
    assign out_pin = (pin_mode == PIN_OFF) ? 1'b0 : pin_q;

endmodule

// File: rtl/cmp_down_timer.sv
module cmp_down_timer
    import cdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq,
    output logic              out_pin
);

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] load_w, cmp_w, cnt_w, start_val_w;
    logic             soft_rst_w, ack_w, ovw_w, start_w, start_load_w;
    logic             tick_w, hit_w, flag_w;
    logic             run_w, rld_w;

    assign run_w = ctrl_q.run;
    assign rld_w = ctrl_q.reload;

    cdt_regs regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .cnt_val    (cnt_w),
        .flag       (flag_w),
        .ctrl       (ctrl_q),
        .load_val   (load_w),
        .cmp_val    (cmp_w),
        .soft_rst   (soft_rst_w),
        .ack        (ack_w),
        .ovw_pulse  (ovw_w),
        .start_pulse(start_w),
        .start_load (start_load_w),
        .start_val  (start_val_w)
    );

    cdt_presc #(.W(PRE_W)) presc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (run_w),
        .restart(start_w || ovw_w || soft_rst_w),
        .divider(ctrl_q.presc),
        .tick   (tick_w)
    );

    cdt_count #(.W(CNT_W)) count_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst_w),
        .run        (run_w),
        .tick       (tick_w),
        .reload     (rld_w),
        .start_pulse(start_w),
        .start_load (start_load_w),
        .start_val  (start_val_w),
        .ovw_pulse  (ovw_w),
        .ovw_val    (bus_wdata),
        .load_val   (load_w),
        .cmp_val    (cmp_w),
        .cnt        (cnt_w),
        .hit        (hit_w)
    );

    cdt_event event_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .soft_rst(soft_rst_w),
        .hit     (hit_w),
        .ack     (ack_w),
        .irq_en  (ctrl_q.irq_en),
        .pin_mode(ctrl_q.pin_mode),
        .flag    (flag_w),
        .irq     (irq),
        .out_pin (out_pin)
    );

endmodule

// File: rtl/cmp_down_timer_chk.sv
module cmp_down_timer_chk
    import cdt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic             run,
    input logic             reload,
    input logic             flag,
    input logic             irq,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cmp
);

    // R5
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !bus_wr) |=> $stable(cnt));

    // R9
    flag_fall_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(bus_wr));

    // R8
    flag_rise_at_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag) && !$past(bus_wr)) |-> (cnt == cmp));

    // R10
    irq_implies_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);

    // R7
    free_run_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt) == '0 && $past(run) && !$past(reload) && !$past(bus_wr) && cnt != '0)
        |-> (cnt == '1));

endmodule

bind cmp_down_timer cmp_down_timer_chk chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .bus_wr(bus_wr),
    .run   (run_w),
    .reload(rld_w),
    .flag  (flag_w),
    .irq   (irq),
    .cnt   (cnt_w),
    .cmp   (cmp_w)
);

// File: tb/cmp_down_timer_tb_top.sv
module cmp_down_timer_tb_top;

    localparam logic [4:0] A_CTRL = 5'h00;
    localparam logic [4:0] A_STAT = 5'h04;
    localparam logic [4:0] A_LOAD = 5'h08;
    localparam logic [4:0] A_CMP  = 5'h0C;
    localparam logic [4:0] A_CNT  = 5'h10;

    localparam logic [31:0] C_EN    = 32'h0000_0001;
    localparam logic [31:0] C_ENMOD = 32'h0000_0002;
    localparam logic [31:0] C_IRQ   = 32'h0000_0004;
    localparam logic [31:0] C_RLD   = 32'h0000_0008;
    localparam logic [31:0] C_SWR   = 32'h0001_0000;
    localparam logic [31:0] C_OVW   = 32'h0002_0000;
    localparam logic [31:0] C_TOG   = 32'h0040_0000;
    localparam logic [31:0] C_CLR   = 32'h0080_0000;
    localparam logic [31:0] C_SET   = 32'h00C0_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, out_pin;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = !clk;

    cmp_down_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .out_pin(out_pin)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic test_reset();
        logic [31:0] d;
        rd(A_CTRL, d); chk("R1 ctrl", d, 32'h0);
        rd(A_STAT, d); chk("R1 status", d, 32'h0);
        rd(A_LOAD, d); chk("R1 load", d, 32'hFFFF_FFFF);
        rd(A_CMP,  d); chk("R1 cmp", d, 32'h0);
        rd(A_CNT,  d); chk("R1 cnt", d, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 pin", {31'b0, out_pin}, 32'h0);
    endtask

    task automatic test_prescale_hold();
        logic [31:0] d, h;
        wr(A_LOAD, 32'd100);
        wr(A_CTRL, C_EN | C_ENMOD | C_RLD | (32'd3 << 4));
        rd(A_CNT, d); chk("R4 start load", d, 32'd100);
        step(8);  rd(A_CNT, d); chk("R3 two steps in 8 clocks", d, 32'd98);
        step(1);  rd(A_CNT, d); chk("R3 no step between ticks", d, 32'd98);
        step(3);  rd(A_CNT, d); chk("R3 third step", d, 32'd97);
        wr(A_CTRL, 32'h0);
        rd(A_CNT, h);
        step(5);  rd(A_CNT, d); chk("R5 hold when off", d, h);
        wr(A_CTRL, C_EN);
        rd(A_CNT, d); chk("R4 resume keeps value", d, h);
        step(1);  rd(A_CNT, d); chk("R4 resume steps down", d, h - 32'd1);
        wr(A_CTRL, 32'h0);
        wr(A_CTRL, C_EN | C_ENMOD);
        rd(A_CNT, d); chk("R4 free-run start all ones", d, 32'hFFFF_FFFF);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic test_reload_match();
        logic [31:0] d;
        wr(A_LOAD, 32'd5);
        wr(A_CMP, 32'd2);
        wr(A_CTRL, C_EN | C_ENMOD | C_IRQ | C_RLD | C_TOG);
        step(3);
        rd(A_CNT, d);  chk("R8 count at match", d, 32'd2);
        rd(A_STAT, d); chk("R8 flag set", d, 32'h1);
        chk("R10 irq high", {31'b0, irq}, 32'h1);
        chk("R11 toggle to 1", {31'b0, out_pin}, 32'h1);
        step(6);
        rd(A_CNT, d);  chk("R6 period load+1", d, 32'd2);
        chk("R11 toggle to 0", {31'b0, out_pin}, 32'h0);
        wr(A_STAT, 32'h0);
        rd(A_STAT, d); chk("R9 write 0 ignored", d, 32'h1);
        wr(A_STAT, 32'h1);
        rd(A_STAT, d); chk("R9 write 1 clears", d, 32'h0);
        chk("R10 irq low after clear", {31'b0, irq}, 32'h0);
        step(1);
        rd(A_CNT, d);  chk("R6 reload at zero", d, 32'd5);
    endtask

    task automatic test_free_run_pins();
        logic [31:0] d;
        wr(A_CTRL, C_SWR | C_EN);
        rd(A_CTRL, d); chk("R13 ctrl cleared", d, 32'h0);
        rd(A_CNT, d);  chk("R13 cnt cleared", d, 32'h0);
        rd(A_STAT, d); chk("R13 flag cleared", d, 32'h0);
        rd(A_LOAD, d); chk("R13 load kept", d, 32'd5);
        rd(A_CMP, d);  chk("R13 cmp kept", d, 32'd2);
        wr(A_LOAD, 32'h55);
        rd(A_CNT, d);  chk("R12 no overwrite when clear", d, 32'h0);
        wr(A_CMP, 32'hFFFF_FFFF);
        wr(A_CTRL, C_EN | C_OVW | C_SET);
        step(1);
        rd(A_CNT, d);  chk("R7 wrap to all ones", d, 32'hFFFF_FFFF);
        rd(A_STAT, d); chk("R8 flag on wrap match", d, 32'h1);
        chk("R10 irq masked", {31'b0, irq}, 32'h0);
        chk("R11 set mode", {31'b0, out_pin}, 32'h1);
        wr(A_CTRL, C_EN | C_OVW);
        chk("R11 mode 0 drives low", {31'b0, out_pin}, 32'h0);
        wr(A_CTRL, C_EN | C_OVW | C_CLR);
        chk("R11 pin state kept", {31'b0, out_pin}, 32'h1);
        rd(A_CTRL, d); chk("R2 ctrl readback", d, 32'h0082_0001);
        wr(A_LOAD, 32'd3);
        rd(A_CNT, d);  chk("R12 overwrite", d, 32'd3);
        wr(A_CMP, 32'd1);
        step(1);
        rd(A_CNT, d);  chk("R8 count at new compare", d, 32'd1);
        chk("R11 clear mode", {31'b0, out_pin}, 32'h0);
        wr(A_CTRL, C_SWR);
        rd(A_STAT, d); chk("R13 flag cleared again", d, 32'h0);
        rd(A_CTRL, d); chk("R2 soft reset bit reads 0", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step(1);
        test_reset();
        test_prescale_hold();
        test_reload_match();
        test_free_run_pins();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule